// File: doc/BRIEF.md
# External Interrupt Edge Flag Controller

This block watches four external interrupt request pins. Each pin passes through a two-stage synchroniser. The synchronised level is then compared with its value one cycle earlier. When the transition matches the polarity chosen for that pin, a pending flag latches. Software sees the block through a byte-wide register window. There it picks rising or falling sensing per pin, sets a per-pin enable mask and clears pending flags by writing zeros.

A single interrupt output is high whenever at least one pending flag also has its enable bit set. The register window spans eight consecutive byte addresses starting at a base parameter (0xF2 by default). Only three of those registers hold live state. The rest read back fixed values, and reserved bits are tied to constant ones or zeros.

Top module: `irq_edge_flag_ctrl`

## Requirements
- R1: After reset, reading addresses 0xF2 through 0xF9 returns 0x70, 0x00, 0x10, 0x00, 0x00, 0x10, 0x00, 0x00 in that order.
- R2: At address 0xF2, bits 3..0 are read/write polarity bits for pins 3..0. Bit 7 always reads 0, bits 6..4 always read 1, and writes to bits 7..4 have no effect.
- R3: With polarity bit 1, a rising edge on pin i sets pending flag i, which reads as bit i of address 0xF7. With polarity bit 0, a falling edge sets it. The flag becomes visible on the third rising clock edge after the pin changes.
- R4: A transition of the opposite direction to the selected polarity leaves the pending flag unchanged.
- R5: Writing address 0xF7 clears every pending flag whose data bit is 0 and leaves every flag whose data bit is 1 as it was. No write can set a flag.
- R6: If a qualifying edge and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R7: Bits 3..0 of address 0xF4 are read/write enables for pins 3..0. The output irq_o is high exactly when some pending flag has its enable bit set.
- R8: Writing a new polarity value while a pin holds a steady level does not set that pin's flag.
- R9: Addresses 0xF3, 0xF5, 0xF6, 0xF8 and 0xF9 read 0x00 and ignore writes. At 0xF4 and 0xF7, bit 4 reads 1 and bits 7..5 read 0.
- R10: A read outside 0xF2..0xF9 returns 0x00, and a write there changes nothing. While rd_en_i is low, rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 4 | External request pins, asynchronous |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, acts on the rising clock edge |
| rd_en_i | input | 1 | Read strobe, read data is combinational |
| rdata_o | output | 8 | Read data, 0x00 when no read is requested |
| irq_o | output | 1 | Combined interrupt request, pending AND enabled |

## Verification
The assertions rely on the bus strobes being stable across each rising clock edge. They also rely on a write and a read never needing to target the same cycle's result. The bench meets both conditions by changing address, data and strobes only on falling edges and by holding one strobe at a time. The pins are treated as asynchronous, but the bench moves them only on falling edges, which fixes when each edge is seen. The collision case is timed so that its clearing write lands on exactly the edge where the synchronised transition is detected.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

  localparam int REG_COUNT = 8;
  localparam int OFF_W     = 3;

  // offsets inside the window that carry live state
  localparam logic [OFF_W-1:0] OFF_POL  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_EN   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_PEND = 3'd5;

  // constant bits each register returns regardless of writes
  function automatic logic [7:0] fixed_bits(input logic [OFF_W-1:0] off);
    case (off)
      OFF_POL:  fixed_bits = 8'h70;
      OFF_EN:   fixed_bits = 8'h10;
      OFF_PEND: fixed_bits = 8'h10;
      default:  fixed_bits = 8'h00;
    endcase
  endfunction

  // polarity 1 = rising, 0 = falling
  function automatic logic edge_hit(input logic pol, input logic cur, input logic prev);
    edge_hit = pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // detection outranks clearing so that no event is dropped
  function automatic logic flag_next(input logic flag, input logic hit, input logic clr);
    flag_next = (flag & ~clr) | hit;
  endfunction

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic hit_o
);
  import irq_edge_pkg::*;

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  // prev_q follows the synchronised level every cycle, so a polarity
  // change alone never produces a detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign hit_o = edge_hit(pol_i, sync_q[MSB], prev_q);

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hF2
) (
  input  logic [ADDR_W-1:0]                addr_i,
  output logic                             in_range_o,
  output logic [irq_edge_pkg::OFF_W-1:0]   off_o
);
  import irq_edge_pkg::*;

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(REG_COUNT);

  logic [ADDR_W-1:0] delta;

  assign delta      = addr_i - BASE;
  assign in_range_o = (addr_i >= BASE) && (delta < SPAN);
  assign off_o      = delta[OFF_W-1:0];

endmodule

// File: rtl/irq_edge_flag_ctrl.sv
module irq_edge_flag_ctrl #(
  parameter int N_SRC       = 4,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE = 8'hF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        irq_pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  import irq_edge_pkg::*;

  localparam int PAD = 8 - N_SRC;

  logic [N_SRC-1:0] pol_q, en_q, pend_q;
  logic [N_SRC-1:0] hit, clr, masked;
  logic             in_range;
  logic [OFF_W-1:0] off;
  logic             wr_ok, pol_we, en_we, pend_we;
  logic [7:0]       live_val;

  irq_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr_i     (addr_i),
    .in_range_o (in_range),
    .off_o      (off)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_pin
    irq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (irq_pin_i[i]),
      .pol_i (pol_q[i]),
      .hit_o (hit[i])
    );
  end

  assign wr_ok   = wr_en_i && in_range;
  assign pol_we  = wr_ok && (off == OFF_POL);
  assign en_we   = wr_ok && (off == OFF_EN);
  assign pend_we = wr_ok && (off == OFF_PEND);
  assign clr     = pend_we ? ~wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      en_q  <= '0;
    end else begin
      if (pol_we) pol_q <= wdata_i[N_SRC-1:0];
      if (en_we)  en_q  <= wdata_i[N_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++)
        pend_q[i] <= flag_next(pend_q[i], hit[i], clr[i]);
    end
  end

  always_comb begin
    case (off)
      OFF_POL:  live_val = {{PAD{1'b0}}, pol_q};
      OFF_EN:   live_val = {{PAD{1'b0}}, en_q};
      OFF_PEND: live_val = {{PAD{1'b0}}, pend_q};
      default:  live_val = 8'h00;
    endcase
  end

  assign rdata_o = (rd_en_i && in_range) ? (fixed_bits(off) | live_val) : 8'h00;
  assign masked  = pend_q & en_q;
  assign irq_o   = |masked;

endmodule

// File: rtl/irq_edge_flag_ctrl_chk.sv
module irq_edge_flag_ctrl_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] hit,
  input logic [N_SRC-1:0] clr,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] en_q,
  input logic             irq_o,
  input logic             rd_en_i,
  input logic             in_range,
  input logic [2:0]       off,
  input logic [7:0]       rdata_o
);

  AST_FLAG_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0)); // R3

  AST_EDGE_ALWAYS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & ~pend_q) == '0)); // R6

  AST_FLAG_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q) & ~$past(clr)) == '0)); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((en_q != '0) && (pend_q != '0))); // R7

  AST_POL_RESERVED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && in_range && off == 3'd0) |-> (rdata_o[7:4] == 4'h7)); // R2

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_range) |-> (rdata_o == 8'h00)); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == 8'h00)); // R10

endmodule

bind irq_edge_flag_ctrl irq_edge_flag_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit      (hit),
  .clr      (clr),
  .pend_q   (pend_q),
  .en_q     (en_q),
  .irq_o    (irq_o),
  .rd_en_i  (rd_en_i),
  .in_range (in_range),
  .off      (off),
  .rdata_o  (rdata_o)
);

// File: tb/irq_edge_flag_ctrl_test.sv
module irq_edge_flag_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'h0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_edge_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .addr_i(addr),
    .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  // pin change, then three rising edges for sync + detect + latch
  task automatic drive_pins(input logic [3:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] exp [8] = '{8'h70, 8'h00, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00};
    for (int k = 0; k < 8; k++) rd_chk("R1 reset value", 8'hF2 + 8'(k), exp[k]);
    chk("R7 irq low after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_out_of_range;
    rd_chk("R10 read below window", 8'hF1, 8'h00);
    rd_chk("R10 read above window", 8'hFA, 8'h00);
    wr(8'hFA, 8'hFF);
    wr(8'hF1, 8'hFF);
    rd_chk("R10 stray write leaves polarity", 8'hF2, 8'h70);
    rd_chk("R10 stray write leaves enables", 8'hF4, 8'h10);
    @(negedge clk); addr = 8'hF2; rd_en = 1'b0; #2;
    chk("R10 no strobe reads zero", rdata, 8'h00);
  endtask

  task automatic t_pol_reg;
    wr(8'hF2, 8'hFF);
    rd_chk("R2 reserved bits fixed on all-ones", 8'hF2, 8'h7F);
    wr(8'hF2, 8'h05);
    rd_chk("R2 pattern 05", 8'hF2, 8'h75);
    wr(8'hF2, 8'h80);
    rd_chk("R2 bit7 write ignored", 8'hF2, 8'h70);
  endtask

  task automatic t_falling;
    wr(8'hF2, 8'h00);
    drive_pins(4'hF);
    rd_chk("R4 rise ignored under falling", 8'hF7, 8'h10);
    @(negedge clk); pins = 4'h0;
    repeat (2) @(negedge clk);
    addr = 8'hF7; rd_en = 1'b1; #2;
    chk("R3 not yet latched after two edges", rdata, 8'h10);
    rd_en = 1'b0;
    @(negedge clk);
    rd_chk("R3 falling latched on third edge", 8'hF7, 8'h1F);
    wr(8'hF7, 8'h00);
    rd_chk("R5 clear all", 8'hF7, 8'h10);
  endtask

  task automatic t_rising;
    wr(8'hF2, 8'h0F);
    drive_pins(4'h5);
    rd_chk("R3 rising on pins 0 and 2", 8'hF7, 8'h15);
    drive_pins(4'h0);
    rd_chk("R4 fall ignored under rising", 8'hF7, 8'h15);
    wr(8'hF7, 8'hFE);
    rd_chk("R5 zero bit clears only flag 0", 8'hF7, 8'h14);
    wr(8'hF7, 8'hFF);
    rd_chk("R5 ones leave flags", 8'hF7, 8'h14);
    wr(8'hF7, 8'h00);
  endtask

  task automatic t_enable;
    wr(8'hF4, 8'hFF);
    rd_chk("R9 enable fixed bits", 8'hF4, 8'h1F);
    wr(8'hF4, 8'h02);
    drive_pins(4'h4);
    chk("R7 masked flag keeps irq low", {7'd0, irq}, 8'h00);
    wr(8'hF4, 8'h06);
    chk("R7 enabled flag raises irq", {7'd0, irq}, 8'h01);
    wr(8'hF7, 8'h00);
    chk("R7 cleared flag drops irq", {7'd0, irq}, 8'h00);
    drive_pins(4'h0);
    wr(8'hF4, 8'h00);
  endtask

  task automatic t_pol_change;
    drive_pins(4'hF);
    wr(8'hF7, 8'h00);
    wr(8'hF2, 8'h00);
    repeat (4) @(negedge clk);
    rd_chk("R8 polarity flip on high pins", 8'hF7, 8'h10);
    drive_pins(4'h0);
    wr(8'hF7, 8'h00);
    wr(8'hF2, 8'h0F);
    repeat (4) @(negedge clk);
    rd_chk("R8 polarity flip on low pins", 8'hF7, 8'h10);
  endtask

  task automatic t_collide;
    drive_pins(4'h1);
    drive_pins(4'h0);
    rd_chk("R6 setup flag 0 pending", 8'hF7, 8'h11);
    @(negedge clk); pins = 4'h1;
    @(negedge clk);
    @(negedge clk);
    addr = 8'hF7; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R6 edge wins over clear", 8'hF7, 8'h11);
    wr(8'hF7, 8'h00);
    rd_chk("R5 clear after collision", 8'hF7, 8'h10);
    drive_pins(4'h0);
  endtask

  task automatic t_reserved;
    logic [7:0] dead [5] = '{8'hF3, 8'hF5, 8'hF6, 8'hF8, 8'hF9};
    for (int k = 0; k < 5; k++) begin
      wr(dead[k], 8'hFF);
      rd_chk("R9 fixed register ignores write", dead[k], 8'h00);
    end
    wr(8'hF7, 8'hFF);
    rd_chk("R5 write of ones cannot set flags", 8'hF7, 8'h10);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_out_of_range();
    t_pol_reg();
    t_falling();
    t_rising();
    t_enable();
    t_pol_change();
    t_collide();
    t_reserved();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule